// File: doc/BRIEF.md
# Flash Read Prefetch Buffer

This block sits between a 32-bit processor read port and a flash array that is read 128 bits at a time and needs a configurable number of wait states per access. Each 128-bit line carries four 32-bit words, at byte offsets 0, 4, 8 and 12. The block keeps three line-wide storage entries. One read buffer receives lines fetched on demand. Two prefetch buffers receive lines fetched ahead of use. A lookup compares the requested line address against the tags of all three entries at once. On a hit, the word comes back in the same cycle.

When the processor reads the second word (word index 1) of a buffered line, the flash is idle and the following line is not held yet, the block starts fetching that following line. With one wait state, straight-line reads therefore cross line boundaries without a stall. A prefetch in flight keeps running through idle cycles on the processor side. A miss on an unrelated line abandons the prefetch and fetches the requested line instead. An invalidate pulse or a synchronous reset marks all three entries empty.

The processor holds its address and read strobe until ready is seen high. The flash side sees a request level and a line address, both held for the whole access. The block samples the 128-bit flash data when its own wait-state counter expires.

Top module: `flash_prefetch_buf`

## Requirements
- R1: A read whose line is held in any entry has cpu_ready_o high in the same cycle, and cpu_rdata_o is bits [32*k+31:32*k] of that line, where k is address bits [3:2].
- R2: A read that misses while the flash is idle has cpu_ready_o first high ws_i+2 cycles after the cycle in which it is first presented (that cycle counts as cycle 0), and returns the correct word.
- R3: A flash access raises fl_req_o in the cycle after its launch, with fl_line_o equal to address bits above bit 3. Both stay steady, and the data is taken ws_i+1 cycles after the launch.
- R4: A ready read of word index 1 starts a fetch of line+1 (fl_req_o high with fl_line_o = line+1 in the next cycle), but only when the flash is idle and line+1 is not already held. A read of any other word starts no fetch.
- R5: With ws_i = 1, back-to-back sequential reads over several lines stall only on the first word of the first line.
- R6: A prefetch in flight is not cancelled by idle cycles. A read of that line waits for the prefetch to complete rather than restarting it.
- R7: A miss on a line other than the one in flight abandons the in-flight prefetch. The requested line appears on fl_line_o in the next cycle, and the abandoned line is not buffered afterwards.
- R8: No line is held in two entries at once. Demand fills go to the read buffer. Successive prefetch fills alternate between the two prefetch buffers, so three distinct lines can hit at the same time.
- R9: One cycle of inval_i, or a synchronous reset, empties every entry, so the next read of a previously held line misses.
- R10: After reset, with no read strobe, cpu_ready_o and fl_req_o are low.
- R11: With ws_i = 0, a miss on an idle flash completes with cpu_ready_o first high 2 cycles after presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inval_i | input | 1 | Pulse that empties all entries and abandons any access |
| ws_i | input | WS_W | Flash wait states, 0 to 15 |
| cpu_addr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1 down to 2) |
| cpu_rd_i | input | 1 | Read strobe, held until ready |
| cpu_rdata_o | output | 32 | Read data, valid with ready |
| cpu_ready_o | output | 1 | Read completes this cycle |
| fl_line_o | output | ADDR_W-4 | Line address of the flash access |
| fl_req_o | output | 1 | Flash access in progress |
| fl_data_i | input | 128 | Flash line data |

## Verification
A corrupted tag or valid flag shows up in the same cycle as a wrong ready or the word of a different line, because hits are resolved combinationally. A broken wait-state counter shows up a few cycles later, as a miss latency different from ws_i+2. Prefetch faults, such as a launch on the wrong word, a prefetch cancelled by a gap, or a stale line kept after an abort, show up within one line of reads: fl_req_o rises in the wrong cycle, a read of the next line stalls, or a line that should be gone still hits. Entry bookkeeping errors, such as duplicate tags or a prefetch that overwrites the wrong buffer, appear as a later hit or miss that contradicts the expected three-line contents.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int WORD_W         = 32;
  localparam int LINE_W         = 128;
  localparam int WORDS_PER_LINE = LINE_W / WORD_W;
  localparam int WIDX_W         = $clog2(WORDS_PER_LINE);
  localparam int OFS_W          = WIDX_W + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;

  // slice one word out of a line
  function automatic word_t pick_word(line_t ln, logic [WIDX_W-1:0] idx);
    return ln[int'(idx)*WORD_W +: WORD_W];
  endfunction

  // word position whose read triggers the early fetch
  function automatic logic is_trigger_word(logic [WIDX_W-1:0] idx);
    return idx == WIDX_W'(1);
  endfunction
endpackage

// File: rtl/fpb_fetch_timer.sv
module fpb_fetch_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            launch,
  input  logic [WS_W-1:0] ws,
  output logic            busy,
  output logic            done
);
  logic [WS_W-1:0] cnt_q;
  logic            busy_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      cnt_q  <= ws;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fpb_tag_match.sv
module fpb_tag_match #(
  parameter int TAG_W = 16,
  parameter int N     = 3
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            vld,
  input  logic [TAG_W-1:0]        probe,
  output logic [N-1:0]            hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == probe);
  end
endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
  import fpb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WS_W   = 4,
  parameter int NUM_PF = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inval_i,
  input  logic [WS_W-1:0]       ws_i,
  input  logic [ADDR_W-1:2]     cpu_addr_i,
  input  logic                  cpu_rd_i,
  output logic [WORD_W-1:0]     cpu_rdata_o,
  output logic                  cpu_ready_o,
  output logic [ADDR_W-OFS_W-1:0] fl_line_o,
  output logic                  fl_req_o,
  input  logic [LINE_W-1:0]     fl_data_i
);
  localparam int LA_W  = ADDR_W - OFS_W;
  localparam int N_BUF = NUM_PF + 1;
  localparam int PTR_W = (NUM_PF > 1) ? $clog2(NUM_PF) : 1;

  function automatic logic [LA_W-1:0] follow_line(logic [LA_W-1:0] ln);
    return ln + 1'b1;
  endfunction

  // request decode
  logic [LA_W-1:0]   req_line;
  logic [LA_W-1:0]   nxt_line;
  logic [WIDX_W-1:0] req_word;
  assign req_line = cpu_addr_i[ADDR_W-1:OFS_W];
  assign req_word = cpu_addr_i[OFS_W-1:2];
  assign nxt_line = follow_line(req_line);

  // entry 0 is the read buffer, entries 1..NUM_PF the prefetch buffers
  logic [N_BUF-1:0][LA_W-1:0] tag_q;
  line_t                      data_q [N_BUF];
  logic [N_BUF-1:0]           vld_q;

  // named internal events
  logic [N_BUF-1:0] hit_vec, nxt_vec, wr_vec;
  logic             hit_any, nxt_present;
  logic             fl_busy, fill_done, fill_commit;
  logic             inflight_match, dmd_launch, pf_launch, launch_w;
  logic [LA_W-1:0]  infl_line_q;
  logic             infl_pf_q;
  logic [PTR_W-1:0] pf_ptr_q;
  line_t            hit_line;

  fpb_tag_match #(.TAG_W(LA_W), .N(N_BUF)) u_look (
    .tags(tag_q), .vld(vld_q), .probe(req_line), .hit(hit_vec)
  );
  fpb_tag_match #(.TAG_W(LA_W), .N(N_BUF)) u_ahead (
    .tags(tag_q), .vld(vld_q), .probe(nxt_line), .hit(nxt_vec)
  );

  assign hit_any     = |hit_vec;
  assign nxt_present = |nxt_vec;

  fpb_fetch_timer #(.WS_W(WS_W)) u_tmr (
    .clk(clk), .rst(rst), .abort(inval_i), .launch(launch_w),
    .ws(ws_i), .busy(fl_busy), .done(fill_done)
  );

  // access control
  assign inflight_match = fl_busy && (infl_line_q == req_line);
  assign dmd_launch     = cpu_rd_i && !hit_any && !inflight_match;
  assign pf_launch      = cpu_ready_o && is_trigger_word(req_word)
                          && !fl_busy && !nxt_present;
  assign launch_w       = dmd_launch || pf_launch;
  assign fill_commit    = fill_done && !inval_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      infl_line_q <= '0;
      infl_pf_q   <= 1'b0;
    end else if (launch_w) begin
      infl_line_q <= dmd_launch ? req_line : nxt_line;
      infl_pf_q   <= pf_launch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inval_i) pf_ptr_q <= '0;
    else if (fill_commit && infl_pf_q)
      pf_ptr_q <= (int'(pf_ptr_q) == NUM_PF - 1) ? '0 : pf_ptr_q + 1'b1;
  end

  // fill target selection
  always_comb begin
    for (int i = 0; i < N_BUF; i++)
      wr_vec[i] = fill_commit &&
                  (infl_pf_q ? (i == 1 + int'(pf_ptr_q)) : (i == 0));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_BUF; i++) begin
      if (wr_vec[i]) begin
        data_q[i] <= fl_data_i;
        tag_q[i]  <= infl_line_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inval_i) vld_q <= '0;
    else                vld_q <= vld_q | wr_vec;
  end

  // read path
  always_comb begin
    hit_line = '0;
    for (int i = 0; i < N_BUF; i++)
      if (hit_vec[i]) hit_line = hit_line | data_q[i];
  end

  assign cpu_ready_o = cpu_rd_i && hit_any;
  assign cpu_rdata_o = pick_word(hit_line, req_word);
  assign fl_req_o    = fl_busy;
  assign fl_line_o   = infl_line_q;
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int LA_W  = 16,
  parameter int WS_W  = 4,
  parameter int N_BUF = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            inval_i,
  input logic [WS_W-1:0] ws_i,
  input logic            cpu_rd_i,
  input logic            cpu_ready_o,
  input logic            fl_req_o,
  input logic [LA_W-1:0] fl_line_o,
  input logic [LA_W-1:0] req_line,
  input logic [N_BUF-1:0] hit_vec,
  input logic            launch_w,
  input logic            pf_launch,
  input logic            fill_done
);
  logic [WS_W:0]   k_q;
  logic [WS_W-1:0] ws_l_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q    <= '0;
      ws_l_q <= '0;
    end else if (launch_w) begin
      k_q    <= '0;
      ws_l_q <= ws_i;
    end else if (fl_req_o) begin
      k_q <= k_q + 1'b1;
    end
  end

  assert_hit_unique_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_fill_time_R3: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> (k_q == {1'b0, ws_l_q}));

  assert_line_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (fl_req_o && $past(fl_req_o) && !$past(launch_w)) |-> $stable(fl_line_o));

  assert_next_line_R4: assert property (@(posedge clk) disable iff (rst)
    (pf_launch && !inval_i) |=> (fl_req_o && fl_line_o == $past(req_line) + 1'b1));

  assert_miss_fetches_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_i && !cpu_ready_o && !inval_i && !fill_done) |=> fl_req_o);

  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(inval_i) |-> !cpu_ready_o);
endmodule

bind flash_prefetch_buf fpb_checker #(
  .LA_W(LA_W), .WS_W(WS_W), .N_BUF(N_BUF)
) chk_i (
  .clk(clk), .rst(rst), .inval_i(inval_i), .ws_i(ws_i),
  .cpu_rd_i(cpu_rd_i), .cpu_ready_o(cpu_ready_o),
  .fl_req_o(fl_req_o), .fl_line_o(fl_line_o), .req_line(req_line),
  .hit_vec(hit_vec), .launch_w(launch_w), .pf_launch(pf_launch),
  .fill_done(fill_done)
);

// File: tb/flash_prefetch_buf_tb_top.sv
module flash_prefetch_buf_tb_top;
  localparam int ADDR_W = 20;
  localparam int LA_W   = ADDR_W - 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inval = 1'b0;
  logic [3:0]        ws = 4'd0;
  logic [ADDR_W-1:2] cpu_addr = '0;
  logic              cpu_rd = 1'b0;
  logic [31:0]       cpu_rdata;
  logic              cpu_ready;
  logic [LA_W-1:0]   fl_line;
  logic              fl_req;
  logic [127:0]      fl_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  int  last_lat;
  logic [LA_W-1:0] snap_line;
  logic            snap_req;

  always #4 clk = ~clk;

  // expected content of one word of a line
  function automatic logic [31:0] img_word(logic [LA_W-1:0] ln, int w);
    return {4'hC, 2'(w), 10'h2A5, ln};
  endfunction

  // flash stand-in: data follows the line address
  assign fl_data = {img_word(fl_line, 3), img_word(fl_line, 2),
                    img_word(fl_line, 1), img_word(fl_line, 0)};

  flash_prefetch_buf dut_i (
    .clk(clk), .rst(rst), .inval_i(inval), .ws_i(ws),
    .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
    .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
    .fl_line_o(fl_line), .fl_req_o(fl_req), .fl_data_i(fl_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // present one read at a negedge, wait for ready, return at the next negedge
  task automatic rd_word(input logic [LA_W-1:0] ln, input int w,
                         input int exp_lat, input string rq);
    logic [31:0] d;
    cpu_addr = {ln, 2'(w)};
    cpu_rd   = 1'b1;
    last_lat = 0;
    snap_req = 1'b0;
    snap_line = '0;
    #1;
    while (!cpu_ready && last_lat < 64) begin
      @(negedge clk);
      #1;
      last_lat++;
      if (last_lat == 1) begin
        snap_req  = fl_req;
        snap_line = fl_line;
      end
    end
    d = cpu_rdata;
    chk({rq, " data"}, d, img_word(ln, w));
    chk({rq, " latency"}, 32'(last_lat), 32'(exp_lat));
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pulse_inval();
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  task automatic start_case(input int w);
    idle(20);
    ws = 4'(w);
    pulse_inval();
  endtask

  // R10: reset state
  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    #1;
    chk("R10 ready", 32'(cpu_ready), 32'd0);
    chk("R10 fl_req", 32'(fl_req), 32'd0);
    @(negedge clk);
  endtask

  // R11: zero wait states
  task automatic t_ws0();
    start_case(0);
    rd_word(16'd3, 0, 2, "R11 ws0 miss");
  endtask

  // R1 R2 R3: miss then hits across all word slots
  task automatic t_miss_hit();
    start_case(3);
    rd_word(16'd7, 0, 5, "R2 miss ws3");
    chk("R3 fl_req during fill", 32'(snap_req), 32'd1);
    chk("R3 fl_line during fill", 32'(snap_line), 32'd7);
    rd_word(16'd7, 1, 0, "R1 word1");
    idle(8);
    rd_word(16'd7, 3, 0, "R1 word3");
    rd_word(16'd7, 2, 0, "R1 word2");
  endtask

  // R4: prefetch trigger rules
  task automatic t_trigger();
    start_case(3);
    rd_word(16'd50, 0, 5, "R4 setup");
    #1;
    chk("R4 no fetch after word0", 32'(fl_req), 32'd0);
    @(negedge clk);
    rd_word(16'd50, 1, 0, "R4 word1");
    #1;
    chk("R4 fetch after word1", 32'(fl_req), 32'd1);
    chk("R4 next line", 32'(fl_line), 32'd51);
    idle(7);
    rd_word(16'd50, 1, 0, "R4 word1 again");
    #1;
    chk("R4 no refetch when present", 32'(fl_req), 32'd0);
    @(negedge clk);
    rd_word(16'd51, 0, 0, "R4 prefetched line");
  endtask

  // R5: sequential stream with one wait state
  task automatic t_stream();
    int stalls;
    start_case(1);
    stalls = 0;
    for (int ln = 60; ln < 65; ln++) begin
      for (int w = 0; w < 4; w++) begin
        rd_word(16'(ln), w, (ln == 60 && w == 0) ? 3 : 0, "R5 stream");
        stalls += last_lat;
      end
    end
    chk("R5 total stall cycles", 32'(stalls), 32'd3);
  endtask

  // R6: gaps do not cancel a prefetch in flight
  task automatic t_gap();
    start_case(6);
    rd_word(16'd80, 0, 8, "R6 setup");
    rd_word(16'd80, 1, 0, "R6 trigger");
    idle(2);
    rd_word(16'd81, 0, 5, "R6 wait on prefetch");
  endtask

  // R7: unrelated miss abandons prefetch
  task automatic t_abort();
    start_case(6);
    rd_word(16'd90, 0, 8, "R7 setup");
    rd_word(16'd90, 1, 0, "R7 trigger");
    rd_word(16'd100, 0, 8, "R7 jump miss");
    chk("R7 line switched", 32'(snap_line), 32'd100);
    rd_word(16'd91, 0, 8, "R7 dropped line misses");
  endtask

  // R8: three entries, alternating prefetch buffers
  task automatic t_entries();
    start_case(2);
    rd_word(16'd30, 0, 4, "R8 fill read buffer");
    rd_word(16'd30, 1, 0, "R8 trigger 31");
    idle(5);
    rd_word(16'd31, 0, 0, "R8 hit 31");
    rd_word(16'd31, 1, 0, "R8 trigger 32");
    idle(5);
    rd_word(16'd30, 2, 0, "R8 hit 30");
    rd_word(16'd31, 2, 0, "R8 hit 31 again");
    rd_word(16'd32, 0, 0, "R8 hit 32");
    rd_word(16'd32, 1, 0, "R8 trigger 33");
    idle(5);
    rd_word(16'd33, 0, 0, "R8 hit 33");
    rd_word(16'd30, 3, 0, "R8 read buffer kept");
    rd_word(16'd31, 0, 4, "R8 evicted 31 misses");
  endtask

  // R9: invalidate and reset empty the entries
  task automatic t_clear();
    start_case(2);
    rd_word(16'd40, 0, 4, "R9 setup");
    rd_word(16'd40, 2, 0, "R9 hit before");
    pulse_inval();
    rd_word(16'd40, 2, 4, "R9 miss after inval");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_word(16'd40, 3, 4, "R9 miss after reset");
  endtask

  initial begin
    t_reset();
    t_ws0();
    t_miss_hit();
    t_trigger();
    t_stream();
    t_gap();
    t_abort();
    t_entries();
    t_clear();
    idle(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule